// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block forms the byte returned by bus reads of one bank of a NOR-style flash array. The embedded program/erase controller supplies its state. While that controller is idle, reads pass the array data through unchanged. While the controller is programming or erasing, every read of the bank returns a status byte instead of array data.

The status byte carries two flags. The polling flag in bit 7 is the inverse of the bit being written during a program operation, and 0 during an erase. The toggle flag in bit 6 changes with each read, which lets software tell that the controller is still busy.

In the erase-suspended state, behaviour depends on the read address. A read inside the block whose erase was suspended returns a status byte with the polling flag set and a frozen toggle flag. A read anywhere else returns ordinary array data.

Top module: `flash_status_responder`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the block is in read mode, and the toggle flag is 0.
- R2: With `op_mode` = 0 (idle), `rd_data` equals `array_data` at any address, including the address just programmed, which therefore shows its true bit 7.
- R3: With `op_mode` = 1 (program), `rd_data[7]` is the inverse of `prog_byte[7]`, whatever the read address.
- R4: With `op_mode` = 2 (erase), `rd_data[7]` is 0, whatever the read address.
- R5: In program or erase mode, `rd_data[6]` inverts once at the clock edge that samples each rising edge of `rd_strobe`, whatever the read address. A strobe held high over several cycles advances the flag only once.
- R6: Whenever the status byte is shown, bits 5 down to 0 of `rd_data` are 0.
- R7: The first read of a program or erase that follows at least one idle clock edge shows `rd_data[6]` = 0.
- R8: With `op_mode` = 3 (erase suspended), a read whose upper address bits (above `BLK_OFF_W`) match those of `op_addr` returns bit 7 = 1 and bits 5..0 = 0. Its bit 6 holds the value the toggle flag had when the suspension began and does not change with further strobes.
- R9: With `op_mode` = 3, a read outside the suspended block returns `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_mode | input | 2 | Controller state: 0 idle, 1 program, 2 erase, 3 erase suspended |
| prog_byte | input | DATA_W | Byte being programmed |
| op_addr | input | ADDR_W | Target address of the program or erase operation |
| rd_addr | input | ADDR_W | Read address |
| rd_strobe | input | 1 | Read strobe; a rising edge counts as one read |
| array_data | input | DATA_W | Data read from the array cells |
| rd_data | output | DATA_W | Byte returned to the bus |

## Verification
The only state in the block is the toggle flag and the delayed strobe. Any fault in either appears in `rd_data[6]` on the very next strobed read. A missed or doubled edge breaks the 0,1,0,1 sequence at once. A flag that is not cleared shows as a 1 on the first read of a new operation. Faults in the selection between status and array data, or in the block match, appear in the same cycle, because `rd_data` is combinational from the inputs and the flag.

// File: rtl/flash_status_responder.sv
module flash_status_responder #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int BLK_OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_mode,
  input  logic [DATA_W-1:0] prog_byte,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [1:0] M_IDLE  = 2'd0;
  localparam logic [1:0] M_PROG  = 2'd1;
  localparam logic [1:0] M_ERASE = 2'd2;
  localparam logic [1:0] M_SUSP  = 2'd3;
  localparam int POLL_BIT = 7;
  localparam int TGL_BIT  = 6;

  logic              tgl_q, stb_q;
  logic              busy, susp, in_blk, stb_rise, show_status;
  logic [DATA_W-1:0] status;

  assign busy     = (op_mode == M_PROG) || (op_mode == M_ERASE);
  assign susp     = (op_mode == M_SUSP);
  assign in_blk   = rd_addr[ADDR_W-1:BLK_OFF_W] == op_addr[ADDR_W-1:BLK_OFF_W];
  assign stb_rise = rd_strobe && !stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      stb_q <= rd_strobe;
      if (op_mode == M_IDLE)
        tgl_q <= 1'b0;
      else if (busy && stb_rise)
        tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    status           = '0;
    status[POLL_BIT] = (op_mode == M_PROG) ? ~prog_byte[POLL_BIT] : susp;
    status[TGL_BIT]  = tgl_q;
  end

  assign show_status = busy || (susp && in_blk);
  assign rd_data     = show_status ? status : array_data;

  logic unused_ok;
  assign unused_ok = ^{prog_byte[POLL_BIT-1:0], op_addr[BLK_OFF_W-1:0], rd_addr[BLK_OFF_W-1:0]};
endmodule

module flash_status_responder_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int BLK_OFF_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_mode,
  input logic [DATA_W-1:0] prog_byte,
  input logic [ADDR_W-1:0] op_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data
);
  logic stb_prev;
  always_ff @(posedge clk) stb_prev <= rst ? 1'b0 : rd_strobe;

  logic busy_c, blk_c;
  assign busy_c = (op_mode == 2'd1) || (op_mode == 2'd2);
  assign blk_c  = rd_addr[ADDR_W-1:BLK_OFF_W] == op_addr[ADDR_W-1:BLK_OFF_W];

  p_idle_pass_r2: assert property (@(posedge clk) disable iff (rst)
    op_mode == 2'd0 |-> rd_data == array_data);
  p_prog_poll_r3: assert property (@(posedge clk) disable iff (rst)
    op_mode == 2'd1 |-> rd_data[7] == !prog_byte[7]);
  p_erase_poll_r4: assert property (@(posedge clk) disable iff (rst)
    op_mode == 2'd2 |-> rd_data[7] == 1'b0);
  p_toggle_step_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_c && rd_strobe && !stb_prev) |=> (!busy_c || rd_data[6] != $past(rd_data[6])));
  p_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
    busy_c |-> rd_data[5:0] == '0);
  p_fresh_op_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(op_mode) == 2'd0 && busy_c) |-> rd_data[6] == 1'b0);
  p_susp_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 2'd3 && blk_c && $past(op_mode) == 2'd3 && $past(blk_c)) |-> $stable(rd_data[6]));
  p_susp_outside_r9: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 2'd3 && !blk_c) |-> rd_data == array_data);
endmodule

bind flash_status_responder flash_status_responder_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W)
) chk_i (
  .clk(clk), .rst(rst), .op_mode(op_mode), .prog_byte(prog_byte),
  .op_addr(op_addr), .rd_addr(rd_addr), .rd_strobe(rd_strobe),
  .array_data(array_data), .rd_data(rd_data)
);

// File: tb/flash_status_responder_tb_top.sv
module flash_status_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_mode = 2'd0;
  logic [7:0] prog_byte = 8'h00;
  logic [15:0] op_addr = 16'h0000;
  logic [15:0] rd_addr = 16'h0000;
  logic       rd_strobe = 1'b0;
  logic [7:0] array_data = 8'h5A;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_status_responder dut_i (
    .clk(clk), .rst(rst), .op_mode(op_mode), .prog_byte(prog_byte),
    .op_addr(op_addr), .rd_addr(rd_addr), .rd_strobe(rd_strobe),
    .array_data(array_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    rd_strobe = 1'b1;
    #5 v = rd_data;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    op_mode = 2'd0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    array_data = 8'h5A;
    do_read(16'h1234, v);
    check("R1", v, 8'h5A);
    check("R2", v, 8'h5A);
  endtask

  task automatic t_program(input logic [7:0] pb, input int nreads);
    logic [7:0] v;
    logic       t = 1'b0;
    @(negedge clk);
    op_addr = 16'h2468;
    prog_byte = pb;
    array_data = 8'hFF;
    op_mode = 2'd1;
    for (int i = 0; i < nreads; i++) begin
      do_read(16'h0100 * i[15:0] + 16'h0007, v);
      check(i == 0 ? "R7" : "R5", v, {~pb[7], t, 6'b0});
      check("R3", {v[7], 7'b0}, {~pb[7], 7'b0});
      check("R6", {2'b0, v[5:0]}, 8'h00);
      t = ~t;
    end
    @(negedge clk);
    op_mode = 2'd0;
    array_data = pb;
    do_read(16'h2468, v);
    check("R2", v, pb);
  endtask

  task automatic t_erase_suspend();
    logic [7:0] v, v2;
    logic       t = 1'b0;
    @(negedge clk);
    op_addr = 16'h3000;
    array_data = 8'h81;
    op_mode = 2'd2;
    for (int i = 0; i < 3; i++) begin
      do_read(16'hF000 - 16'h1000 * i[15:0], v);
      check(i == 0 ? "R7" : "R5", v, {1'b0, t, 6'b0});
      check("R4", {v[7], 7'b0}, 8'h00);
      t = ~t;
    end
    @(negedge clk);
    op_mode = 2'd3;
    do_read(16'h3ABC, v);
    check("R8", v, {1'b1, t, 6'b0});
    do_read(16'h3001, v2);
    check("R8", v2, {1'b1, t, 6'b0});
    do_read(16'h7ABC, v);
    check("R9", v, 8'h81);
    @(negedge clk);
    op_mode = 2'd2;
    do_read(16'h3000, v);
    check("R5", v, {1'b0, t, 6'b0});
    do_read(16'h3000, v);
    check("R5", v, {1'b0, ~t, 6'b0});
    idle_cycle();
    array_data = 8'hFF;
    do_read(16'h3000, v);
    check("R2", v, 8'hFF);
  endtask

  task automatic t_held_strobe();
    logic [7:0] v;
    @(negedge clk);
    op_addr = 16'h0000;
    prog_byte = 8'h80;
    op_mode = 2'd1;
    rd_addr = 16'h0040;
    rd_strobe = 1'b1;
    #5 check("R5", rd_data, 8'h00);
    @(negedge clk);
    #5 check("R5", rd_data, 8'h40);
    @(negedge clk);
    #5 check("R5", rd_data, 8'h40);
    @(negedge clk);
    #5 check("R5", rd_data, 8'h40);
    rd_strobe = 1'b0;
    do_read(16'h0040, v);
    check("R5", v, 8'h40);
    do_read(16'h0040, v);
    check("R5", v, 8'h00);
    idle_cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program(8'h3C, 4);
    idle_cycle();
    t_program(8'hC3, 3);
    idle_cycle();
    t_erase_suspend();
    t_held_strobe();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule